// File: doc/BRIEF.md
# Bundle Register Writeback Arbiter

This block collects the register-file writes made by the up to four instructions of one issue bundle and commits them together. The four instructions come from the scalar, address, vector and branch slots. Each write request names a target file (scalar, vector, address or loop), a register index and data. The scalar slot also says what kind of move it is. Every register file is a small storage model with one combinational read port. All reads inside a bundle cycle therefore see the contents from before the bundle. All writes land on the same rising edge.

Some bundles have two or more live requests aimed at the same register of one file. For those, the winner comes from a fixed order. The order is different for each file and depends on the instruction kind, not only on the slot. A scalar write is cancelled when that scalar instruction reads the loop file and the branch slot in the same bundle performs an exit. Each collision raises a conflict bit for that file for one cycle. A testbench or a trace monitor can watch these bits.

Top module: `bundle_wb_arbiter`

## Requirements
- R1: Writes take effect on the rising edge where `commit` is 1. Read ports show the previous contents during the commit cycle. With `commit` at 0, no register changes, even if write enables are set.
- R2: Scalar file collision order, highest first: (1) a scalar write with `sc_weak`=0 and `sc_from_loop`=0; (2) an address write; (3) a scalar write with `sc_weak`=1 or `sc_from_loop`=1.
- R3: Vector file collision order: vector slot, then address slot, then scalar slot. A scalar write to the vector file copies `sc_data` into all four 32-bit lanes.
- R4: Address file collision order: a scalar move beats the address slot. Scalar-file and address-file writes from the address slot use `ad_data[31:0]`.
- R5: Loop file collision order: branch slot beats scalar slot. A scalar write uses `sc_data[15:0]` and the index `sc_dst[1:0]`.
- R6: Scalar register 31 always reads 0. Writes to it are dropped, and they do not count toward a conflict.
- R7: When `sc_from_loop` and `br_exit` are both 1 in a commit cycle, the scalar write to the scalar file is cancelled. An address write to the same register then lands. With no other write, the register keeps its old value.
- R8: `conflict` bit 0 (scalar), 1 (vector), 2 (address) or 3 (loop) is 1 for exactly the cycle after a commit. It is set only when two or more live requests hit the same register of that file. All bits are 0 after a cycle with no commit.
- R9: Writes to different registers or different files in one bundle all land on the same edge.
- R10: `rst_n` low clears all registers and `conflict` at once, without waiting for a clock edge. Release takes effect after two rising edges.
- R11: `sc_dfile` and `ad_dfile` select the target file: 0 scalar, 1 vector, 2 address, 3 loop. An address request with value 3 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | Bundle commit strobe |
| sc_we | input | 1 | Scalar slot write request |
| sc_dfile | input | 2 | Scalar slot target file |
| sc_dst | input | 5 | Scalar slot destination index |
| sc_weak | input | 1 | Scalar move from condition, vector or address file |
| sc_from_loop | input | 1 | Scalar move from loop file |
| sc_data | input | 32 | Scalar slot write data |
| ad_we | input | 1 | Address slot write request |
| ad_dfile | input | 2 | Address slot target file |
| ad_dst | input | 5 | Address slot destination index |
| ad_data | input | 128 | Address slot write data |
| vu_we | input | 1 | Vector slot write request |
| vu_dst | input | 5 | Vector slot destination index |
| vu_data | input | 128 | Vector slot write data |
| br_we | input | 1 | Branch slot loop-register write |
| br_dst | input | 2 | Branch slot loop index |
| br_data | input | 16 | Branch slot loop data |
| br_exit | input | 1 | Branch slot performs an exit |
| rd_r_idx | input | 5 | Scalar read index |
| rd_r_data | output | 32 | Scalar read data |
| rd_v_idx | input | 5 | Vector read index |
| rd_v_data | output | 128 | Vector read data |
| rd_a_idx | input | 5 | Address read index |
| rd_a_data | output | 32 | Address read data |
| rd_l_idx | input | 2 | Loop read index |
| rd_l_data | output | 16 | Loop read data |
| conflict | output | 4 | Per-file collision flags |

## Verification
The bench builds the block with its default parameters: 32 registers per main file, 32-bit words, four vector lanes and four 16-bit loop registers. With 32 registers, the hard-zero index 31 falls inside the 5-bit destination field. With four loop registers, the loop index is narrower than the destination field, so dropping the upper destination bits can be tested. With four lanes, a scalar-to-vector copy has to show up in every lane.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  typedef enum logic [1:0] {
    FILE_R = 2'd0,
    FILE_V = 2'd1,
    FILE_A = 2'd2,
    FILE_L = 2'd3
  } rfile_e;

  localparam int CONF_R = 0;
  localparam int CONF_V = 1;
  localparam int CONF_A = 2;
  localparam int CONF_L = 3;
endpackage

// File: rtl/bwa_rst_sync.sv
module bwa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bwa_regfile.sv
// One register file: priority-ordered request slots (slot 0 highest),
// per-register winner select, same-register conflict detection.
module bwa_regfile #(
  parameter int NREG      = 32,
  parameter int W         = 32,
  parameter int NREQ      = 2,
  parameter bit HARD_ZERO = 1'b0,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [NREQ-1:0]   req_we,
  input  logic [NREQ*IW-1:0] req_idx,
  input  logic [NREQ*W-1:0] req_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [W-1:0]      rd_data,
  output logic              conflict
);
  logic [W-1:0]    mem_q [NREG];
  logic [W-1:0]    mem_d [NREG];
  logic [NREQ-1:0] live;
  logic            conf_d, conf_q;

  // a request is live only in a commit cycle and never for the hard-zero slot
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      live[i] = commit && req_we[i] &&
                !(HARD_ZERO && (req_idx[i*IW +: IW] == IW'(NREG-1)));
    end
  end

  // next state: walk lowest priority first so slot 0 is applied last
  always_comb begin
    mem_d = mem_q;
    for (int r = 0; r < NREG; r++) begin
      for (int i = NREQ-1; i >= 0; i--) begin
        if (live[i] && (req_idx[i*IW +: IW] == IW'(r))) begin
          mem_d[r] = req_data[i*W +: W];
        end
      end
    end
  end

  always_comb begin
    conf_d = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      for (int j = i + 1; j < NREQ; j++) begin
        if (live[i] && live[j] && (req_idx[i*IW +: IW] == req_idx[j*IW +: IW])) begin
          conf_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem_q[r] <= '0;
      conf_q <= 1'b0;
    end else begin
      conf_q <= conf_d;
      if (commit) mem_q <= mem_d;
    end
  end

  assign rd_data  = (HARD_ZERO && (rd_idx == IW'(NREG-1))) ? '0 : mem_q[rd_idx];
  assign conflict = conf_q;
endmodule

// File: rtl/bundle_wb_arbiter.sv
module bundle_wb_arbiter
  import bwa_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int SW    = 32,
  parameter int LANES = 4,
  parameter int NLOOP = 4,
  parameter int LW    = 16,
  localparam int IW  = $clog2(NREG),
  localparam int LIW = $clog2(NLOOP),
  localparam int VW  = LANES * SW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic           sc_we,
  input  logic [1:0]     sc_dfile,
  input  logic [IW-1:0]  sc_dst,
  input  logic           sc_weak,
  input  logic           sc_from_loop,
  input  logic [SW-1:0]  sc_data,
  input  logic           ad_we,
  input  logic [1:0]     ad_dfile,
  input  logic [IW-1:0]  ad_dst,
  input  logic [VW-1:0]  ad_data,
  input  logic           vu_we,
  input  logic [IW-1:0]  vu_dst,
  input  logic [VW-1:0]  vu_data,
  input  logic           br_we,
  input  logic [LIW-1:0] br_dst,
  input  logic [LW-1:0]  br_data,
  input  logic           br_exit,
  input  logic [IW-1:0]  rd_r_idx,
  output logic [SW-1:0]  rd_r_data,
  input  logic [IW-1:0]  rd_v_idx,
  output logic [VW-1:0]  rd_v_data,
  input  logic [IW-1:0]  rd_a_idx,
  output logic [SW-1:0]  rd_a_data,
  input  logic [LIW-1:0] rd_l_idx,
  output logic [LW-1:0]  rd_l_data,
  output logic [3:0]     conflict
);
  logic rst_core_n;
  logic sc_kill, sc_to_r, sc_is_weak;
  logic sc_to_v, sc_to_a, sc_to_l, ad_to_r, ad_to_v, ad_to_a;

  bwa_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  always_comb begin
    sc_kill    = sc_from_loop && br_exit;
    sc_is_weak = sc_weak || sc_from_loop;
    sc_to_r    = sc_we && (sc_dfile == FILE_R) && !sc_kill;
    sc_to_v    = sc_we && (sc_dfile == FILE_V);
    sc_to_a    = sc_we && (sc_dfile == FILE_A);
    sc_to_l    = sc_we && (sc_dfile == FILE_L);
    ad_to_r    = ad_we && (ad_dfile == FILE_R);
    ad_to_v    = ad_we && (ad_dfile == FILE_V);
    ad_to_a    = ad_we && (ad_dfile == FILE_A);
  end

  // scalar file: strong scalar > address load > weak scalar move
  bwa_regfile #(.NREG(NREG), .W(SW), .NREQ(3), .HARD_ZERO(1'b1)) u_rf_r (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .commit   (commit),
    .req_we   ({sc_to_r && sc_is_weak, ad_to_r, sc_to_r && !sc_is_weak}),
    .req_idx  ({sc_dst, ad_dst, sc_dst}),
    .req_data ({sc_data, ad_data[SW-1:0], sc_data}),
    .rd_idx   (rd_r_idx),
    .rd_data  (rd_r_data),
    .conflict (conflict[CONF_R])
  );

  // vector file: vector slot > address load > scalar move
  bwa_regfile #(.NREG(NREG), .W(VW), .NREQ(3), .HARD_ZERO(1'b0)) u_rf_v (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .commit   (commit),
    .req_we   ({sc_to_v, ad_to_v, vu_we}),
    .req_idx  ({sc_dst, ad_dst, vu_dst}),
    .req_data ({{LANES{sc_data}}, ad_data, vu_data}),
    .rd_idx   (rd_v_idx),
    .rd_data  (rd_v_data),
    .conflict (conflict[CONF_V])
  );

  // address file: scalar move > address slot
  bwa_regfile #(.NREG(NREG), .W(SW), .NREQ(2), .HARD_ZERO(1'b0)) u_rf_a (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .commit   (commit),
    .req_we   ({ad_to_a, sc_to_a}),
    .req_idx  ({ad_dst, sc_dst}),
    .req_data ({ad_data[SW-1:0], sc_data}),
    .rd_idx   (rd_a_idx),
    .rd_data  (rd_a_data),
    .conflict (conflict[CONF_A])
  );

  // loop file: branch slot > scalar move
  bwa_regfile #(.NREG(NLOOP), .W(LW), .NREQ(2), .HARD_ZERO(1'b0)) u_rf_l (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .commit   (commit),
    .req_we   ({sc_to_l, br_we}),
    .req_idx  ({sc_dst[LIW-1:0], br_dst}),
    .req_data ({sc_data[LW-1:0], br_data}),
    .rd_idx   (rd_l_idx),
    .rd_data  (rd_l_data),
    .conflict (conflict[CONF_L])
  );
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker
  import bwa_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int SW    = 32,
  parameter int LANES = 4,
  parameter int NLOOP = 4,
  parameter int LW    = 16,
  localparam int IW  = $clog2(NREG),
  localparam int LIW = $clog2(NLOOP),
  localparam int VW  = LANES * SW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           commit,
  input logic           sc_we,
  input logic [1:0]     sc_dfile,
  input logic [IW-1:0]  sc_dst,
  input logic           sc_from_loop,
  input logic [SW-1:0]  sc_data,
  input logic           ad_we,
  input logic [1:0]     ad_dfile,
  input logic [IW-1:0]  ad_dst,
  input logic           vu_we,
  input logic [IW-1:0]  vu_dst,
  input logic [VW-1:0]  vu_data,
  input logic           br_we,
  input logic [LIW-1:0] br_dst,
  input logic [LW-1:0]  br_data,
  input logic           br_exit,
  input logic [IW-1:0]  rd_r_idx,
  input logic [SW-1:0]  rd_r_data,
  input logic [IW-1:0]  rd_v_idx,
  input logic [VW-1:0]  rd_v_data,
  input logic [IW-1:0]  rd_a_idx,
  input logic [SW-1:0]  rd_a_data,
  input logic [LIW-1:0] rd_l_idx,
  input logic [LW-1:0]  rd_l_data,
  input logic [3:0]     conflict
);
  assert_r31_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_r_idx == IW'(NREG-1)) |-> (rd_r_data == '0));

  assert_vec_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && vu_we) |=> ((rd_v_idx != $past(vu_dst)) || (rd_v_data == $past(vu_data))));

  assert_amove_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sc_we && (sc_dfile == FILE_A)) |=>
      ((rd_a_idx != $past(sc_dst)) || (rd_a_data == $past(sc_data))));

  assert_branch_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && br_we) |=> ((rd_l_idx != $past(br_dst)) || (rd_l_data == $past(br_data))));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ((rd_r_idx != $past(rd_r_idx)) || $stable(rd_r_data)));

  assert_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sc_we && (sc_dfile == FILE_R) && sc_from_loop && br_exit &&
     !(ad_we && (ad_dfile == FILE_R) && (ad_dst == sc_dst)) && (rd_r_idx == sc_dst)) |=>
      ((rd_r_idx != $past(rd_r_idx)) || $stable(rd_r_data)));

  assert_conf_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (conflict == 4'b0000));

  assert_conf_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sc_we && (sc_dfile == FILE_R) && ad_we && (ad_dfile == FILE_R) &&
     (sc_dst == ad_dst) && (sc_dst != IW'(NREG-1)) && !(sc_from_loop && br_exit)) |=> conflict[CONF_R]);
endmodule

bind bundle_wb_arbiter bwa_checker u_chk (.*);

// File: tb/tb_bundle_wb_arbiter.sv
`timescale 1ns/1ps
module tb_bundle_wb_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic commit;
  logic sc_we, sc_weak, sc_from_loop;
  logic [1:0] sc_dfile;
  logic [4:0] sc_dst;
  logic [31:0] sc_data;
  logic ad_we;
  logic [1:0] ad_dfile;
  logic [4:0] ad_dst;
  logic [127:0] ad_data;
  logic vu_we;
  logic [4:0] vu_dst;
  logic [127:0] vu_data;
  logic br_we, br_exit;
  logic [1:0] br_dst;
  logic [15:0] br_data;
  logic [4:0] rd_r_idx, rd_v_idx, rd_a_idx;
  logic [1:0] rd_l_idx;
  logic [31:0] rd_r_data, rd_a_data;
  logic [127:0] rd_v_data;
  logic [15:0] rd_l_data;
  logic [3:0] conflict;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bundle_wb_arbiter dut (.*);

  typedef struct packed {
    logic sc_we; logic [1:0] sc_dfile; logic [4:0] sc_dst; logic sc_weak; logic sc_fl; logic [31:0] sc_data;
    logic ad_we; logic [1:0] ad_dfile; logic [4:0] ad_dst; logic [31:0] ad_data;
    logic vu_we; logic [4:0] vu_dst; logic [31:0] vu_data;
    logic br_we; logic [1:0] br_dst; logic [15:0] br_data; logic br_exit;
    logic [1:0] cf; logic [4:0] ci; logic [31:0] ex; logic [3:0] ec; logic [3:0] tag;
  } vec_t;

  localparam int NROWS = 15;
  localparam vec_t TBL [NROWS] = '{
    // R2 strong scalar beats address
    '{1'b1,2'd0,5'd3,1'b0,1'b0,32'hA1A10001, 1'b1,2'd0,5'd3,32'hB1B10001, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd0,5'd3,32'hA1A10001,4'b0001,4'd2},
    // R2 address beats weak scalar move
    '{1'b1,2'd0,5'd4,1'b1,1'b0,32'hC1C10001, 1'b1,2'd0,5'd4,32'hD1D10001, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd0,5'd4,32'hD1D10001,4'b0001,4'd2},
    // R2 move from loop is weak
    '{1'b1,2'd0,5'd6,1'b0,1'b1,32'hE1E10001, 1'b1,2'd0,5'd6,32'hF1F10001, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd0,5'd6,32'hF1F10001,4'b0001,4'd2},
    // R3 vector beats address beats scalar
    '{1'b1,2'd1,5'd7,1'b0,1'b0,32'h33333333, 1'b1,2'd1,5'd7,32'h22222222, 1'b1,5'd7,32'h11111111, 1'b0,2'd0,16'h0,1'b0, 2'd1,5'd7,32'h11111111,4'b0010,4'd3},
    // R3 address beats scalar
    '{1'b1,2'd1,5'd8,1'b0,1'b0,32'h55555555, 1'b1,2'd1,5'd8,32'h44444444, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd1,5'd8,32'h44444444,4'b0010,4'd3},
    // R3 scalar replicated into lanes
    '{1'b1,2'd1,5'd9,1'b0,1'b0,32'h66666666, 1'b0,2'd0,5'd0,32'h0, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd1,5'd9,32'h66666666,4'b0000,4'd3},
    // R4 scalar move beats address
    '{1'b1,2'd2,5'd2,1'b0,1'b0,32'h77777777, 1'b1,2'd2,5'd2,32'h88888888, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd2,5'd2,32'h77777777,4'b0100,4'd4},
    // R4 address alone, low word
    '{1'b0,2'd0,5'd0,1'b0,1'b0,32'h0, 1'b1,2'd2,5'd3,32'h99999999, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd2,5'd3,32'h99999999,4'b0000,4'd4},
    // R5 branch beats scalar
    '{1'b1,2'd3,5'd1,1'b0,1'b0,32'hABCD5678, 1'b0,2'd0,5'd0,32'h0, 1'b0,5'd0,32'h0, 1'b1,2'd1,16'h1234,1'b0, 2'd3,5'd1,32'h00001234,4'b1000,4'd5},
    // R5 scalar index truncated to 2 bits, low 16 data bits
    '{1'b1,2'd3,5'd6,1'b0,1'b0,32'h1234BEEF, 1'b0,2'd0,5'd0,32'h0, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd3,5'd2,32'h0000BEEF,4'b0000,4'd5},
    // R6 writes to register 31 dropped, no conflict
    '{1'b1,2'd0,5'd31,1'b0,1'b0,32'hDEADDEAD, 1'b1,2'd0,5'd31,32'hBEEFBEEF, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd0,5'd31,32'h0,4'b0000,4'd6},
    // R7 exit kills loop move, address lands
    '{1'b1,2'd0,5'd10,1'b0,1'b1,32'h11110000, 1'b1,2'd0,5'd10,32'h22220000, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b1, 2'd0,5'd10,32'h22220000,4'b0000,4'd7},
    // R7 exit kills loop move, register kept
    '{1'b1,2'd0,5'd20,1'b0,1'b1,32'h33330000, 1'b0,2'd0,5'd0,32'h0, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b1, 2'd0,5'd20,32'h0,4'b0000,4'd7},
    // R11 address request to file 3 dropped
    '{1'b0,2'd0,5'd0,1'b0,1'b0,32'h0, 1'b1,2'd3,5'd0,32'h44440000, 1'b0,5'd0,32'h0, 1'b0,2'd0,16'h0,1'b0, 2'd3,5'd0,32'h0,4'b0000,4'd11},
    // R9 four files in one bundle
    '{1'b1,2'd0,5'd12,1'b0,1'b0,32'h55550000, 1'b1,2'd2,5'd12,32'h66660000, 1'b1,5'd12,32'h77770000, 1'b1,2'd3,16'h8888,1'b0, 2'd0,5'd12,32'h55550000,4'b0000,4'd9}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    commit = 1'b0; sc_we = 1'b0; sc_dfile = 2'd0; sc_dst = 5'd0; sc_weak = 1'b0; sc_from_loop = 1'b0;
    sc_data = '0; ad_we = 1'b0; ad_dfile = 2'd0; ad_dst = 5'd0; ad_data = '0; vu_we = 1'b0;
    vu_dst = 5'd0; vu_data = '0; br_we = 1'b0; br_dst = 2'd0; br_data = '0; br_exit = 1'b0;
  endtask

  function automatic logic [127:0] read_file(input logic [1:0] f);
    case (f)
      2'd0:    return {96'h0, rd_r_data};
      2'd1:    return rd_v_data;
      2'd2:    return {96'h0, rd_a_data};
      default: return {112'h0, rd_l_data};
    endcase
  endfunction

  task automatic set_rd(input logic [1:0] f, input logic [4:0] i);
    case (f)
      2'd0:    rd_r_idx = i;
      2'd1:    rd_v_idx = i;
      2'd2:    rd_a_idx = i;
      default: rd_l_idx = i[1:0];
    endcase
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rd_r_idx = 5'd0; rd_v_idx = 5'd0; rd_a_idx = 5'd0; rd_l_idx = 2'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 reset clears registers and conflict", {conflict, rd_r_data, rd_v_data[31:0], rd_a_data, rd_l_data},
        {4'h0, 32'h0, 32'h0, 32'h0, 16'h0});

    for (int k = 0; k < NROWS; k++) begin
      @(negedge clk);
      commit = 1'b1;
      sc_we = TBL[k].sc_we; sc_dfile = TBL[k].sc_dfile; sc_dst = TBL[k].sc_dst;
      sc_weak = TBL[k].sc_weak; sc_from_loop = TBL[k].sc_fl; sc_data = TBL[k].sc_data;
      ad_we = TBL[k].ad_we; ad_dfile = TBL[k].ad_dfile; ad_dst = TBL[k].ad_dst; ad_data = {4{TBL[k].ad_data}};
      vu_we = TBL[k].vu_we; vu_dst = TBL[k].vu_dst; vu_data = {4{TBL[k].vu_data}};
      br_we = TBL[k].br_we; br_dst = TBL[k].br_dst; br_data = TBL[k].br_data; br_exit = TBL[k].br_exit;
      @(negedge clk);
      idle_inputs();
      set_rd(TBL[k].cf, TBL[k].ci);
      #1;
      chk($sformatf("R%0d row %0d data", TBL[k].tag, k), read_file(TBL[k].cf),
          (TBL[k].cf == 2'd1) ? {4{TBL[k].ex}} : {96'h0, TBL[k].ex});
      chk($sformatf("R8 row %0d conflict", k), {124'h0, conflict}, {124'h0, TBL[k].ec});
    end

    // R9 remaining writes of the four-file bundle landed on the same edge
    rd_a_idx = 5'd12; rd_v_idx = 5'd12; rd_l_idx = 2'd3;
    #1;
    chk("R9 address file", {96'h0, rd_a_data}, {96'h0, 32'h66660000});
    chk("R9 vector file", rd_v_data, {4{32'h77770000}});
    chk("R9 loop file", {112'h0, rd_l_data}, {112'h0, 16'h8888});

    // R1 read before write inside the commit cycle
    @(negedge clk);
    rd_r_idx = 5'd3;
    commit = 1'b1; sc_we = 1'b1; sc_dfile = 2'd0; sc_dst = 5'd3; sc_data = 32'hCAFE0001;
    #1;
    chk("R1 old value visible during commit", {96'h0, rd_r_data}, {96'h0, 32'hA1A10001});
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R1 new value after commit edge", {96'h0, rd_r_data}, {96'h0, 32'hCAFE0001});

    // R1 write enable without commit has no effect
    @(negedge clk);
    sc_we = 1'b1; sc_dfile = 2'd0; sc_dst = 5'd3; sc_data = 32'hF00D0001;
    ad_we = 1'b1; ad_dfile = 2'd0; ad_dst = 5'd3; ad_data = {4{32'hF00D0002}};
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R1 no commit keeps register", {96'h0, rd_r_data}, {96'h0, 32'hCAFE0001});
    chk("R8 no commit no conflict", {124'h0, conflict}, 128'h0);

    // R10 asynchronous clear in mid-cycle
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R10 asynchronous clear", {96'h0, rd_r_data}, 128'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule